// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block is a clocked front end for an external asynchronous static RAM of 131,072 bytes. A client hands it single-byte transfers through a valid/ready handshake. Each request carries a 17-bit address, a write flag and, for writes, a data byte. The controller then sequences the active-low chip-enable, write-enable and output-enable strobes toward the memory. A completed read comes back as a registered byte with a one-cycle valid pulse.

The bidirectional memory data bus is split into three signals: a data-out byte, a drive enable and a data-in byte. Two parameters set the strobe widths, one for reads and one for writes. Each is the memory's cycle time divided by the clock period, rounded up, so one design fits several speed grades. The write width must be at least 2.

Writes are controlled by write-enable. The memory latches the byte on the rising edge of write-enable, so the controller keeps the address, the data and its drive steady through that edge. After a read it leaves one idle turnaround cycle before it takes the next request. Its own driver is never on while the memory may be driving the bus.

Top module: `asram_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip-enable, write-enable and output-enable are high (inactive), the drive enable is low, `rd_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only when no transfer is in progress, and chip-enable is then high. A request presented while `req_ready` is low is ignored: it starts no memory cycle and produces no read data.
- R3: An accepted read (`req_write` = 0) holds chip-enable and output-enable low with write-enable high for exactly READ_WAIT cycles. These start in the cycle after acceptance, and `mem_addr` equals the request address throughout.
- R4: Read data is the `mem_dq_in` value sampled at the end of the last output-enable-low cycle. It appears on `rd_data` with `rd_valid` high for exactly one cycle: the first cycle in which output-enable is high again.
- R5: An accepted write (`req_write` = 1) holds chip-enable and write-enable low with output-enable high for exactly WRITE_WAIT cycles, starting in the cycle after acceptance.
- R6: The drive enable rises one cycle after write-enable falls. It stays high with chip-enable low for one cycle after write-enable rises, and `mem_addr` and `mem_dq_out` do not change across the write-enable rising edge.
- R7: The drive enable is never high while output-enable is low, and write-enable and output-enable are never low together.
- R8: After a read, the cycle that carries `rd_valid` has chip-enable and output-enable high, the drive enable low and `req_ready` low. `req_ready` returns high in the following cycle.
- R9: After a write, chip-enable rises and the drive enable falls together, one cycle after write-enable rises. `req_ready` is high in that same cycle.
- R10: A read returns the byte most recently written to its address, including at address 0 and at the top address 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | DATA_W | Registered read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | DATA_W | Byte read from the memory bus |

## Verification
Call the accepting clock edge E0. For a read with READ_WAIT = R, the strobes go low after E0 and stay low through E_R. `rd_valid` and the data appear after E_R, and `req_ready` returns after E_R+1. For a write with WRITE_WAIT = W, write-enable is low after E0. The drive enable rises after E1, write-enable rises after E_W, and the controller is idle again after E_W+1. Every bench task samples on the falling clock edge and walks these edges one by one, checking each strobe in the exact half-cycle it is due, so a result one cycle early or late fails.

// File: rtl/asram_port.sv
module asram_port #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int READ_WAIT  = 2,
  parameter int WRITE_WAIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int MAXW = (READ_WAIT > WRITE_WAIT) ? READ_WAIT : WRITE_WAIT;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WR, S_WHOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          take;

  assign req_ready = (st == S_IDLE);
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          if (req_write) begin
            mem_we_n   <= 1'b0;
            mem_dq_out <= req_wdata;
            cnt        <= CW'(WRITE_WAIT - 1);
            st         <= S_WR;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(READ_WAIT - 1);
            st       <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rd_data  <= mem_dq_in;
          rd_valid <= 1'b1;
          mem_oe_n <= 1'b1;
          mem_ce_n <= 1'b1;
          st       <= S_TURN;
        end else begin
          cnt <= cnt - 1'b1;
        end
        S_TURN: st <= S_IDLE;
        S_WR: begin
          mem_dq_oe <= 1'b1;
          if (cnt == '0) begin
            mem_we_n <= 1'b1;
            st       <= S_WHOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHOLD: begin
          mem_ce_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module asram_port_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid));

  // R2
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  // R3
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  // R3
  read_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr));

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R4
  rd_at_oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(mem_oe_n));

  // R5
  write_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  // R6
  drive_after_we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_dq_oe ##1 mem_dq_oe));

  // R6
  we_rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_out)));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_ce_n && !req_ready) ##1 (!mem_dq_oe && mem_we_n));

  // R9
  drive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> (mem_we_n && $past(mem_we_n) && mem_ce_n));

endmodule

bind asram_port asram_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_asram_port.sv
module test_asram_port;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int RW = 3;
  localparam int WW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int checks = 0;
  int failures = 0;
  int rv_count = 0;
  int conflicts = 0;
  int mem_gen = 0;
  logic [DW-1:0] model [int];

  always #5 clk = ~clk;

  asram_port #(.ADDR_W(AW), .DATA_W(DW), .READ_WAIT(RW), .WRITE_WAIT(WW)) i_asram_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      model[int'(mem_addr)] = mem_dq_oe ? mem_dq_out : 'x;
      mem_gen++;
    end
  end

  always @(mem_ce_n or mem_oe_n or mem_we_n or mem_addr or mem_gen) begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in = 'z;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) rv_count++;
      if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) conflicts++;
      if (!mem_we_n && !mem_oe_n) conflicts++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    chk("R2", "ready before write", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5", "we low after accept", 32'(mem_we_n), 0);
    chk("R5", "ce low after accept", 32'(mem_ce_n), 0);
    chk("R5", "oe high in write", 32'(mem_oe_n), 1);
    chk("R6", "no drive in first we cycle", 32'(mem_dq_oe), 0);
    chk("R2", "ready low in write", 32'(req_ready), 0);
    for (int k = 1; k < WW; k++) begin
      @(negedge clk);
      chk("R5", "we still low", 32'(mem_we_n), 0);
      chk("R6", "drive on", 32'(mem_dq_oe), 1);
      chk("R6", "address held", 32'(mem_addr), 32'(a));
      chk("R6", "data held", 32'(mem_dq_out), 32'(d));
    end
    @(negedge clk);
    chk("R5", "we high after WW cycles", 32'(mem_we_n), 1);
    chk("R6", "ce low in hold", 32'(mem_ce_n), 0);
    chk("R6", "drive held past we rise", 32'(mem_dq_oe), 1);
    chk("R6", "data at we rise", 32'(mem_dq_out), 32'(d));
    @(negedge clk);
    chk("R9", "ce high after hold", 32'(mem_ce_n), 1);
    chk("R9", "drive off after hold", 32'(mem_dq_oe), 0);
    chk("R9", "ready after write", 32'(req_ready), 1);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int rv0;
    rv0 = rv_count;
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    chk("R2", "ready before read", 32'(req_ready), 1);
    for (int k = 0; k < RW; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3", "ce low in read", 32'(mem_ce_n), 0);
      chk("R3", "oe low in read", 32'(mem_oe_n), 0);
      chk("R3", "we high in read", 32'(mem_we_n), 1);
      chk("R3", "read address", 32'(mem_addr), 32'(a));
      chk("R4", "no early rd_valid", 32'(rd_valid), 0);
    end
    @(negedge clk);
    chk("R4", "rd_valid after RW cycles", 32'(rd_valid), 1);
    chk("R10", "read data", 32'(rd_data), 32'(exp));
    chk("R8", "oe high in turnaround", 32'(mem_oe_n), 1);
    chk("R8", "ce high in turnaround", 32'(mem_ce_n), 1);
    chk("R8", "no drive in turnaround", 32'(mem_dq_oe), 0);
    chk("R8", "ready low in turnaround", 32'(req_ready), 0);
    @(negedge clk);
    chk("R4", "rd_valid one cycle", 32'(rd_valid), 0);
    chk("R8", "ready after turnaround", 32'(req_ready), 1);
    chk("R4", "one pulse per read", 32'(rv_count - rv0), 1);
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "ce in reset", 32'(mem_ce_n), 1);
    chk("R1", "we in reset", 32'(mem_we_n), 1);
    chk("R1", "oe in reset", 32'(mem_oe_n), 1);
    chk("R1", "drive in reset", 32'(mem_dq_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", 32'(req_ready), 1);
    chk("R1", "rd_valid after reset", 32'(rd_valid), 0);
    chk("R1", "ce after reset", 32'(mem_ce_n), 1);
  endtask

  task automatic test_ignored_request();
    int rv0;
    rv0 = rv_count;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00777; req_wdata = 8'h11;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00555;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (WW) @(negedge clk);
    chk("R2", "idle after busy write", 32'(req_ready), 1);
    repeat (3) begin
      @(negedge clk);
      chk("R2", "ignored request starts no cycle", 32'(mem_ce_n), 1);
    end
    chk("R2", "ignored request gives no data", 32'(rv_count - rv0), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    do_write(17'h00000, 8'hA5);
    do_write(17'h1FFFF, 8'h5A);
    do_write(17'h12345, 8'h3C);
    do_read(17'h00000, 8'hA5);
    do_read(17'h1FFFF, 8'h5A);
    do_read(17'h12345, 8'h3C);
    do_read(17'h12345, 8'h3C);
    do_write(17'h12345, 8'hC3);
    do_read(17'h12345, 8'hC3);
    test_ignored_request();
    do_read(17'h00777, 8'h11);
    do_read(17'h00555, 8'h00);
    chk("R7", "no bus contention or strobe overlap", 32'(conflicts), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule